// File: doc/BRIEF.md
# Windowed Discrete PI Controller

This block is a sampled, fixed-point proportional-integral regulator that steers processor core utilisation toward a target. Utilisation and target both arrive as unsigned fractions scaled so that 0 means no busy cores and 255 means all cores busy. On each sampling strobe the block forms the signed error (target minus measured) and stores it in a circular buffer that holds the most recent errors. It then publishes a saturated control value equal to the proportional gain times the current error, plus the integral gain times the sum of the errors held in that buffer.

The integral path is a finite sliding window, not an unbounded accumulator. A running sum adds the newest error and removes the one that falls out of the window. A flush request empties the window, for example after the operating point of the cores has changed and the old errors no longer describe the present state. There is no derivative path. Gain tuning and utilisation measurement happen outside the block.

Top module: `pi_window_ctrl`

## Requirements
- R1: While reset is asserted and after its release, the output value is zero and the valid flag is low until the first sampling strobe.
- R2: The error used at a strobe is the signed difference setpoint minus measured utilisation, both taken as unsigned 8-bit values (range -255..+255).
- R3: The valid flag is high for exactly the one cycle that follows each cycle in which the sampling strobe is high, and is low otherwise.
- R4: On valid, the output equals gain_p times the current error plus gain_i times the sum of the window errors, the current error included. Both gains are signed 8-bit values.
- R5: The window holds the last W errors (W = 8 by default). An error more than W strobes old no longer contributes to the integral term.
- R6: A flush request empties the window. The next output's integral term covers only the errors sampled after the flush.
- R7: When a flush and a strobe fall in the same cycle, the flush acts first and the new error becomes the only entry of the window.
- R8: The output is saturated to the signed range of the 16-bit output, +32767 and -32768 by default.
- R9: Between strobes the output value holds unchanged, whatever the gains, setpoint or utilisation do.
- R10: A flush request without a strobe produces no valid pulse and leaves the output value unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| smp_stb | input | 1 | Sampling strobe, one cycle per sampling interval |
| clr_win | input | 1 | Flush the error window |
| util_meas | input | 8 | Measured utilisation, 0..255 |
| util_setpt | input | 8 | Utilisation target, 0..255 |
| gain_p | input | 8 | Signed proportional gain |
| gain_i | input | 8 | Signed integral gain |
| ctl_out | output | 16 | Signed, saturated control value |
| ctl_vld | output | 1 | One-cycle pulse marking a fresh control value |

## Verification
The hardest state to reach from the ports is a full window that has started to wrap, at the same moment a flush and a strobe coincide. Only then do the dropped oldest entry, the reset pointer and the single new entry all meet. The stimulus first runs more than W strobes with distinct errors and a unit integral gain, so the output shows the bare window sum and the eviction of old errors can be seen. It then issues the flush and the strobe together, and one further strobe, and compares each output against an independent model of the window.

// File: rtl/pi_ctrl_pkg.sv
package pi_ctrl_pkg;

   // Width of a signed error formed from two unsigned operands
   function automatic int err_width(input int uw);
      return uw + 1;
   endfunction

   // Width of a signed sum of depth errors, with one guard bit
   function automatic int sum_width(input int ew, input int depth);
      return ew + $clog2(depth) + 1;
   endfunction

endpackage

// File: rtl/pi_err_window.sv
module pi_err_window #(
   parameter int EW = 9,
   parameter int W  = 8,
   parameter int SW = 13
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 push,
   input  logic                 flush,
   input  logic signed [EW-1:0] din,
   output logic signed [SW-1:0] sum_nxt
);

   localparam int PW     = (W > 1) ? $clog2(W) : 1;
   localparam bit POW2   = ((1 << PW) == W);

   initial begin
      assert (W >= 2) else $error("window depth must be at least 2");
      assert (SW >= EW + $clog2(W)) else $error("sum width too small");
   end

   logic signed [EW-1:0] ring_q [W];
   logic [PW-1:0]        ptr_q;
   logic [PW-1:0]        wr_ptr;
   logic [PW-1:0]        ptr_inc;
   logic signed [SW-1:0] sum_q;
   logic signed [SW-1:0] base_sum;
   logic signed [SW-1:0] oldest;

   assign wr_ptr   = flush ? '0 : ptr_q;
   assign base_sum = flush ? '0 : sum_q;
   assign oldest   = flush ? '0 : SW'(ring_q[ptr_q]);

   generate
      if (POW2) begin : g_wrap_natural
         assign ptr_inc = wr_ptr + PW'(1);
      end else begin : g_wrap_compare
         assign ptr_inc = (wr_ptr == PW'(W - 1)) ? '0 : wr_ptr + PW'(1);
      end
   endgenerate

   always_comb begin
      if (push) sum_nxt = base_sum + SW'(din) - oldest;
      else      sum_nxt = base_sum;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < W; i++) ring_q[i] <= '0;
         ptr_q <= '0;
         sum_q <= '0;
      end else begin
         if (flush) begin
            for (int i = 0; i < W; i++) ring_q[i] <= '0;
            ptr_q <= '0;
         end
         if (push) begin
            ring_q[wr_ptr] <= din;
            ptr_q          <= ptr_inc;
         end
         sum_q <= sum_nxt;
      end
   end

endmodule

// File: rtl/pi_sat_mac.sv
module pi_sat_mac #(
   parameter int EW = 9,
   parameter int SW = 13,
   parameter int GW = 8,
   parameter int OW = 16
) (
   input  logic signed [EW-1:0] err,
   input  logic signed [SW-1:0] win_sum,
   input  logic signed [GW-1:0] kp,
   input  logic signed [GW-1:0] ki,
   output logic signed [OW-1:0] y
);

   localparam int ACCW = GW + SW + 1;

   initial begin
      assert (OW >= 2) else $error("output width must be at least 2");
      assert (SW >= EW) else $error("sum narrower than error");
   end

   logic signed [ACCW-1:0] kp_x, ki_x, err_x, sum_x;
   logic signed [ACCW-1:0] acc;

   assign kp_x  = ACCW'(kp);
   assign ki_x  = ACCW'(ki);
   assign err_x = ACCW'(err);
   assign sum_x = ACCW'(win_sum);
   assign acc   = kp_x * err_x + ki_x * sum_x;

   generate
      if (OW >= ACCW) begin : g_no_clip
         assign y = OW'(acc);
      end else begin : g_clip
         localparam logic signed [ACCW-1:0] MAXV =
            {{(ACCW - OW + 1){1'b0}}, {(OW - 1){1'b1}}};
         localparam logic signed [ACCW-1:0] MINV = ~MAXV;
         always_comb begin
            if (acc > MAXV)      y = MAXV[OW-1:0];
            else if (acc < MINV) y = MINV[OW-1:0];
            else                 y = acc[OW-1:0];
         end
      end
   endgenerate

endmodule

// File: rtl/pi_window_ctrl.sv
module pi_window_ctrl
   import pi_ctrl_pkg::*;
#(
   parameter int UW = 8,
   parameter int W  = 8,
   parameter int GW = 8,
   parameter int OW = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 smp_stb,
   input  logic                 clr_win,
   input  logic [UW-1:0]        util_meas,
   input  logic [UW-1:0]        util_setpt,
   input  logic signed [GW-1:0] gain_p,
   input  logic signed [GW-1:0] gain_i,
   output logic signed [OW-1:0] ctl_out,
   output logic                 ctl_vld
);

   localparam int EW = err_width(UW);
   localparam int SW = sum_width(EW, W);

   initial begin
      assert (UW >= 1) else $error("utilisation width must be positive");
      assert (GW >= 2) else $error("gain width must be at least 2");
   end

   logic signed [EW-1:0] err_now;
   logic signed [SW-1:0] sum_nxt;
   logic signed [OW-1:0] y_nxt;

   assign err_now = $signed({1'b0, util_setpt}) - $signed({1'b0, util_meas});

   pi_err_window #(.EW(EW), .W(W), .SW(SW)) u_window (
      .clk     (clk),
      .rst_n   (rst_n),
      .push    (smp_stb),
      .flush   (clr_win),
      .din     (err_now),
      .sum_nxt (sum_nxt)
   );

   pi_sat_mac #(.EW(EW), .SW(SW), .GW(GW), .OW(OW)) u_mac (
      .err     (err_now),
      .win_sum (sum_nxt),
      .kp      (gain_p),
      .ki      (gain_i),
      .y       (y_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_out <= '0;
         ctl_vld <= 1'b0;
      end else begin
         ctl_vld <= smp_stb;
         if (smp_stb) ctl_out <= y_nxt;
      end
   end

endmodule

// File: rtl/pi_window_ctrl_chk.sv
module pi_window_ctrl_chk #(
   parameter int UW = 8,
   parameter int GW = 8,
   parameter int OW = 16
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 smp_stb,
   input logic                 clr_win,
   input logic [UW-1:0]        util_meas,
   input logic [UW-1:0]        util_setpt,
   input logic signed [GW-1:0] gain_p,
   input logic signed [GW-1:0] gain_i,
   input logic signed [OW-1:0] ctl_out,
   input logic                 ctl_vld
);

   localparam longint OMAX = (64'sd1 <<< (OW - 1)) - 1;
   localparam longint OMIN = -(64'sd1 <<< (OW - 1));

   function automatic longint clip(input longint v);
      if (v > OMAX) return OMAX;
      if (v < OMIN) return OMIN;
      return v;
   endfunction

   longint p_only;
   assign p_only = clip(longint'(gain_p) *
                        (longint'(util_setpt) - longint'(util_meas)));

   logic signed [OW-1:0] p_only_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) p_only_q <= '0;
      else        p_only_q <= OW'(p_only);
   end

   // R3: a strobe is followed by a valid pulse
   p_vld_after_stb_r3: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> ctl_vld);

   // R3: no valid pulse without a preceding strobe
   p_no_vld_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> !ctl_vld);

   // R9: output holds while no fresh value is flagged
   p_hold_between_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_vld |-> $stable(ctl_out));

   // R10: a flush alone yields no pulse and no output change
   p_flush_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_win && !smp_stb) |=> (!ctl_vld && $stable(ctl_out)));

   // R4: with zero integral gain the output is the proportional term alone
   p_prop_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && gain_i == '0) |=> (ctl_out == p_only_q));

endmodule

bind pi_window_ctrl pi_window_ctrl_chk #(.UW(UW), .GW(GW), .OW(OW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .smp_stb    (smp_stb),
   .clr_win    (clr_win),
   .util_meas  (util_meas),
   .util_setpt (util_setpt),
   .gain_p     (gain_p),
   .gain_i     (gain_i),
   .ctl_out    (ctl_out),
   .ctl_vld    (ctl_vld)
);

// File: tb/test_pi_window_ctrl.sv
module test_pi_window_ctrl;

   localparam int W = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              smp_stb = 1'b0;
   logic              clr_win = 1'b0;
   logic [7:0]        util_meas = '0;
   logic [7:0]        util_setpt = '0;
   logic signed [7:0] gain_p = '0;
   logic signed [7:0] gain_i = '0;
   logic signed [15:0] ctl_out;
   logic              ctl_vld;

   int n_chk = 0;
   int n_bad = 0;

   int mwin [W];
   int mptr = 0;

   always #10 clk = ~clk;

   pi_window_ctrl i_pi_window_ctrl (
      .clk, .rst_n, .smp_stb, .clr_win, .util_meas, .util_setpt,
      .gain_p, .gain_i, .ctl_out, .ctl_vld
   );

   function automatic int clip16(input int v);
      if (v > 32767)  return 32767;
      if (v < -32768) return -32768;
      return v;
   endfunction

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic model_flush();
      for (int i = 0; i < W; i++) mwin[i] = 0;
      mptr = 0;
   endtask

   // One strobe (optionally with a flush), check value on the pulse cycle
   task automatic strobe(input int u, input int sp, input bit clr,
                         input string req);
      int e, s, exp;
      e = sp - u;
      if (clr) model_flush();
      mwin[mptr] = e;
      mptr = (mptr + 1) % W;
      s = 0;
      for (int i = 0; i < W; i++) s += mwin[i];
      exp = clip16(int'(gain_p) * e + int'(gain_i) * s);
      @(negedge clk);
      util_meas = u[7:0]; util_setpt = sp[7:0];
      smp_stb = 1'b1; clr_win = clr;
      @(negedge clk);
      smp_stb = 1'b0; clr_win = 1'b0;
      check({req, " valid"}, int'(ctl_vld), 1);
      check({req, " value"}, int'(ctl_out), exp);
   endtask

   task automatic t_reset();
      check("R1 reset valid", int'(ctl_vld), 0);
      check("R1 reset out", int'(ctl_out), 0);
      @(negedge clk); rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R1 after release valid", int'(ctl_vld), 0);
      check("R1 after release out", int'(ctl_out), 0);
   endtask

   task automatic t_proportional();
      gain_p = 8'sd2; gain_i = 8'sd0;
      strobe(50, 200, 1'b0, "R2 R4 positive error");
      strobe(250, 10, 1'b0, "R2 R4 negative error");
      strobe(77, 77, 1'b0, "R2 zero error");
   endtask

   task automatic t_pulse_hold();
      int held;
      gain_p = 8'sd3; gain_i = 8'sd1;
      strobe(20, 60, 1'b0, "R4 mixed gains");
      held = int'(ctl_out);
      @(negedge clk);
      check("R3 single cycle pulse", int'(ctl_vld), 0);
      gain_p = -8'sd50; util_meas = 8'd255; util_setpt = 8'd0;
      repeat (3) @(negedge clk);
      check("R9 output held", int'(ctl_out), held);
      check("R3 no pulse while idle", int'(ctl_vld), 0);
   endtask

   task automatic t_window_roll();
      gain_p = 8'sd0; gain_i = 8'sd1;
      strobe(0, 0, 1'b1, "R6 flush with zero sample");
      for (int k = 0; k < W + 4; k++)
         strobe(10 * k, 100 + 3 * k, 1'b0, "R5 window eviction");
   endtask

   task automatic t_flush_only();
      int held;
      held = int'(ctl_out);
      @(negedge clk); clr_win = 1'b1;
      @(negedge clk); clr_win = 1'b0;
      check("R10 flush no pulse", int'(ctl_vld), 0);
      check("R10 flush keeps out", int'(ctl_out), held);
      model_flush();
      strobe(40, 90, 1'b0, "R6 integral after flush");
      strobe(90, 40, 1'b0, "R6 two samples after flush");
   endtask

   task automatic t_flush_and_strobe();
      for (int k = 0; k < W + 2; k++)
         strobe(5 * k, 200, 1'b0, "R5 refill");
      strobe(30, 130, 1'b1, "R7 flush with strobe");
      strobe(60, 70, 1'b0, "R7 following strobe");
   endtask

   task automatic t_saturation();
      gain_p = 8'sd127; gain_i = 8'sd127;
      strobe(0, 255, 1'b1, "R8 upper clip first");
      strobe(0, 255, 1'b0, "R8 upper clip");
      gain_p = -8'sd128; gain_i = 8'sd0;
      strobe(0, 255, 1'b1, "R8 negative prop");
      gain_p = 8'sd127; gain_i = 8'sd127;
      strobe(255, 0, 1'b1, "R8 lower clip");
   endtask

   initial begin
      for (int i = 0; i < W; i++) mwin[i] = 0;
      t_reset();
      t_proportional();
      t_pulse_hold();
      t_window_roll();
      t_flush_only();
      t_flush_and_strobe();
      t_saturation();
      repeat (3) @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule